// File: doc/BRIEF.md
# Serial Bias Register Slave

This block is the control port of a dual-port line driver. An external controller reaches it over three wires: an active-low select, a serial clock and a single data line that carries traffic both ways. Every access is a 12-bit frame: a direction flag, then a 3-bit register address, then 8 data bits. The address and data fields are sent least significant bit first. Two 8-bit registers, one per port, sit at addresses 3 and 7. The low seven bits of each register are the port's quiescent-current code, one step per LSB.

The top bit of each register has a second role. When both top bits are set, the boost request from the line-driver controller is blocked. Both registers come out of reset with only the top bit set, so boost stays off after power-up until software clears one of those bits.

All three serial pins are synchronized into the system clock domain, so the serial clock must run well below the system clock. The data line is modelled as an input, an output and an output-enable; the pad buffer sits outside the block.

Top module: `serial_bias_regs`

## Requirements
- R1: After reset both registers hold 8'h80. Both current codes are 0, boost_en is 0 whatever boost_req is, and sdata_oe is 0.
- R2: A frame is sampled on rising serial-clock edges while cs_n is low. Bit 0 is the direction: 1 writes, 0 reads. Bits 1..3 are address bits 0..2. Bits 4..11 are data bits 0..7. Address 3 selects port AB and address 7 selects port CD.
- R3: A write changes the addressed register only when cs_n rises after all 12 bits have arrived. A frame with fewer bits changes nothing.
- R4: On a read, the register's bit 0 appears on sdata_out after the first falling serial-clock edge that follows the 4th bit. Each later falling edge presents the next bit, up to bit 7.
- R5: sdata_oe is high only during the 8-bit data phase of a read. It is 0 during the command bits, during any write, after the 12th falling edge and while cs_n is high.
- R6: Writes to any address other than 3 or 7 change no register. Reads of such an address drive eight zeros.
- R7: boost_en equals boost_req, one system clock later, except that it is 0 while bit 7 of both registers is 1.
- R8: Serial clocks beyond the 12th in one select period are ignored. They do not alter the captured frame or the value written.
- R9: The bit counter returns to zero only on a falling serial-clock edge while cs_n is high. If no such edge comes between two frames, the second frame is ignored.
- R10: Each port's current code is the low 7 bits of its register. Bit 7 does not affect it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| sdata_in | input | 1 | Data line as seen at the pad |
| sdata_out | output | 1 | Read data to the pad driver |
| sdata_oe | output | 1 | Pad driver enable |
| boost_req | input | 1 | Boost request from the line-driver controller |
| ab_iq_code | output | 7 | Quiescent-current code for port AB |
| cd_iq_code | output | 7 | Quiescent-current code for port CD |
| boost_en | output | 1 | Gated boost enable |

## Verification
The bench builds the block with its default parameters:
- 8-bit registers and a 3-bit address.
- Ports at addresses 3 and 7.
- A reset value of 8'h80.
- Two synchronizer stages.

With the serial half-period set to eight system clocks, each serial edge is detected well inside its half-period, so every read bit can be sampled just before the next rising edge. Because the address field is 3 bits wide, unused addresses exist, so the ignore rules for writes and reads can be exercised. The top-bit combinations that block boost can also be reached both by directed writes and by random ones.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
  localparam int DW        = 8;
  localparam int AW        = 3;
  localparam int CMD_LEN   = 1 + AW;
  localparam int FRAME_LEN = CMD_LEN + DW;
  localparam int NPORT     = 2;
  localparam int CODE_W    = DW - 1;

  typedef struct packed {
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } wr_req_t;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  always_ff @(posedge clk) begin
    if (rst) sr <= {STAGES{RST_LVL}};
    else     sr <= {sr[STAGES-2:0], d};
  end

  assign q = sr[STAGES-1];
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
  import spi3_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          sclk_s,
  input  logic          sdi_s,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output wr_req_t       wr,
  output logic          wr_en,
  output logic          sd_out,
  output logic          sd_oe
);
  localparam int CNT_W = $clog2(FRAME_LEN + 1);

  logic [CNT_W-1:0] cnt;
  logic             rw, pend, cs_d, sclk_d;
  logic [AW-1:0]    addr;
  logic [DW-1:0]    data;
  logic             rise, fall, cs_rise;

  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign cs_rise = cs_s & ~cs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0; rw <= 1'b0; pend <= 1'b0; cs_d <= 1'b1; sclk_d <= 1'b0;
      addr <= '0; data <= '0; wr_en <= 1'b0; sd_out <= 1'b0; sd_oe <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
      wr_en  <= 1'b0;
      if (cs_s) begin
        sd_oe  <= 1'b0;
        sd_out <= 1'b0;
        if (cs_rise && pend) wr_en <= 1'b1;
        if (cs_rise || fall) pend <= 1'b0;
        if (fall) cnt <= '0;
      end else begin
        if (rise && cnt < CNT_W'(FRAME_LEN)) begin
          cnt <= cnt + 1'b1;
          if (cnt == '0) rw <= sdi_s;
          for (int i = 0; i < AW; i++)
            if (cnt == CNT_W'(1 + i)) addr[i] <= sdi_s;
          for (int i = 0; i < DW; i++)
            if (cnt == CNT_W'(CMD_LEN + i)) data[i] <= sdi_s;
          if (cnt == CNT_W'(FRAME_LEN - 1) && rw) pend <= 1'b1;
        end
        if (fall) begin
          sd_oe <= 1'b0;
          for (int i = 0; i < DW; i++)
            if (!rw && cnt == CNT_W'(CMD_LEN + i)) begin
              sd_oe  <= 1'b1;
              sd_out <= rd_data[i];
            end
        end
      end
    end
  end

  assign rd_addr = addr;
  assign wr      = '{addr: addr, data: data};

  AST_OE_ONLY_READ: assert property (@(posedge clk) disable iff (rst)
    sd_oe |-> !rw); // R5
  AST_OE_DESELECT: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> !sd_oe); // R5
  AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (rst)
    (cnt == CNT_W'(FRAME_LEN) && !cs_s) |=> cnt == CNT_W'(FRAME_LEN)); // R8
  AST_WR_IS_WRITE: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (rw && cs_s)); // R3
endmodule

// File: rtl/spi3_regs.sv
module spi3_regs
  import spi3_pkg::*;
#(
  parameter logic [DW-1:0] RST_VAL = 8'h80,
  parameter logic [AW-1:0] ADDR_AB = 3'd3,
  parameter logic [AW-1:0] ADDR_CD = 3'd7
) (
  input  logic              clk,
  input  logic              rst,
  input  wr_req_t           wr,
  input  logic              wr_en,
  input  logic [AW-1:0]     rd_addr,
  input  logic              boost_req,
  output logic [DW-1:0]     rd_data,
  output logic [CODE_W-1:0] code [NPORT],
  output logic              boost_en
);
  localparam logic [AW-1:0] PORT_ADDR [NPORT] = '{ADDR_AB, ADDR_CD};

  logic [DW-1:0] bank [NPORT];
  logic [NPORT-1:0] top_bits;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst)                                    bank[g] <= RST_VAL;
      else if (wr_en && wr.addr == PORT_ADDR[g])  bank[g] <= wr.data;
    end
    assign code[g]     = bank[g][CODE_W-1:0];
    assign top_bits[g] = bank[g][DW-1];

    AST_RESET_VALUE: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> bank[g] == RST_VAL); // R1
    AST_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(bank[g])); // R3
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NPORT; i++)
      if (rd_addr == PORT_ADDR[i]) rd_data = bank[i];
  end

  always_ff @(posedge clk) begin
    if (rst) boost_en <= 1'b0;
    else     boost_en <= boost_req & ~(&top_bits);
  end

  AST_BOOST_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    (&top_bits) |=> !boost_en); // R7
endmodule

// File: rtl/serial_bias_regs.sv
module serial_bias_regs
  import spi3_pkg::*;
#(
  parameter int            SYNC_STAGES = 2,
  parameter logic [DW-1:0] RST_VAL     = 8'h80,
  parameter logic [AW-1:0] ADDR_AB     = 3'd3,
  parameter logic [AW-1:0] ADDR_CD     = 3'd7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  input  logic              boost_req,
  output logic [CODE_W-1:0] ab_iq_code,
  output logic [CODE_W-1:0] cd_iq_code,
  output logic              boost_en
);
  logic          cs_s, sclk_s, sdi_s, wr_en;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] rd_addr;
  wr_req_t       wr;
  logic [CODE_W-1:0] code [NPORT];

  spi3_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b1)) u_cs   (.clk(clk), .rst(rst), .d(cs_n),     .q(cs_s));
  spi3_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b0)) u_sclk (.clk(clk), .rst(rst), .d(sclk),     .q(sclk_s));
  spi3_sync #(.STAGES(SYNC_STAGES), .RST_LVL(1'b0)) u_sdi  (.clk(clk), .rst(rst), .d(sdata_in), .q(sdi_s));

  spi3_frame u_frame (
    .clk(clk), .rst(rst), .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr(wr), .wr_en(wr_en),
    .sd_out(sdata_out), .sd_oe(sdata_oe)
  );

  spi3_regs #(.RST_VAL(RST_VAL), .ADDR_AB(ADDR_AB), .ADDR_CD(ADDR_CD)) u_regs (
    .clk(clk), .rst(rst), .wr(wr), .wr_en(wr_en), .rd_addr(rd_addr),
    .boost_req(boost_req), .rd_data(rd_data), .code(code), .boost_en(boost_en)
  );

  assign ab_iq_code = code[0];
  assign cd_iq_code = code[1];
endmodule

// File: tb/serial_bias_regs_test.sv
module serial_bias_regs_test;
  localparam int CLK_PERIOD = 10;
  localparam int HB = 8;

  logic clk = 0, rst = 1, cs_n = 1, sclk = 0, sdata_in = 0, boost_req = 1;
  logic sdata_out, sdata_oe, boost_en;
  logic [6:0] ab_iq_code, cd_iq_code;
  int checks = 0, fails = 0;
  logic [7:0] e3 = 8'h80, e7 = 8'h80;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_bias_regs uut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .boost_req(boost_req),
    .ab_iq_code(ab_iq_code), .cd_iq_code(cd_iq_code), .boost_en(boost_en)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ticks(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] exp_read(input logic [2:0] a);
    return (a == 3'd3) ? e3 : (a == 3'd7) ? e7 : 8'h00;
  endfunction

  function automatic bit exp_boost(input bit req);
    return req & ~(e3[7] & e7[7]);
  endfunction

  // R2 R4 R5: drive nclk bits; live=0 when the frame must be ignored (R9)
  task automatic xfer(input bit rw, input logic [2:0] a, input logic [7:0] d,
                      input int nclk, input bit live, input bit clr,
                      output logic [7:0] rd);
    rd = '0;
    cs_n = 0;
    ticks(HB);
    for (int i = 0; i < nclk; i++) begin
      sdata_in = (i == 0) ? rw : (i < 4) ? a[i-1] : (i < 12) ? d[i-4] : ~sdata_in;
      ticks(HB);
      chk(sdata_oe == (live && !rw && i >= 4 && i < 12), "R5 oe", sdata_oe, live && !rw && i >= 4 && i < 12);
      if (i >= 4 && i < 12) rd[i-4] = sdata_out;
      sclk = 1;
      ticks(HB);
      sclk = 0;
    end
    ticks(HB);
    chk(sdata_oe == 0, "R5 oe after frame", sdata_oe, 0);
    cs_n = 1;
    ticks(HB);
    if (clr) begin
      sclk = 1; ticks(HB); sclk = 0; ticks(HB);
    end
    chk(sdata_oe == 0, "R5 oe deselected", sdata_oe, 0);
  endtask

  task automatic check_state(input string req);
    chk(ab_iq_code == e3[6:0], {req, " ab code"}, ab_iq_code, e3[6:0]);
    chk(cd_iq_code == e7[6:0], {req, " cd code"}, cd_iq_code, e7[6:0]);
    chk(boost_en == exp_boost(boost_req), {req, " boost"}, boost_en, exp_boost(boost_req));
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    logic [7:0] r;
    xfer(1'b1, a, d, 12, 1, 1, r);
    if (a == 3'd3) e3 = d;
    else if (a == 3'd7) e7 = d;
  endtask

  task automatic rd_chk(input logic [2:0] a, input string req);
    logic [7:0] r;
    xfer(1'b0, a, 8'h00, 12, 1, 1, r);
    chk(r == exp_read(a), req, r, exp_read(a));
  endtask

  initial begin
    logic [7:0] r;
    void'($urandom(32'd20240611));
    ticks(4);
    rst = 0;
    ticks(2);
    // R1: reset state with boost requested
    check_state("R1");
    chk(sdata_oe == 0, "R1 oe", sdata_oe, 0);
    rd_chk(3'd3, "R1 R4 read reg3 reset");
    rd_chk(3'd7, "R1 R4 read reg7 reset");
    // R2 R7: write port AB, boost released
    wr(3'd3, 8'h1C);
    check_state("R2 R7");
    // R10: bit 7 set does not alter the code
    wr(3'd7, 8'h9C);
    check_state("R10");
    rd_chk(3'd7, "R4 read 9C");
    // R7: both top bits set blocks boost
    wr(3'd3, 8'hC9);
    check_state("R7 blocked");
    boost_req = 0; ticks(3); check_state("R7 req low");
    boost_req = 1;
    // R3: short frame ignored
    xfer(1'b1, 3'd3, 8'h55, 8, 1, 1, r);
    check_state("R3 short");
    rd_chk(3'd3, "R3 read after short");
    // R8: extra clocks after bit 12
    xfer(1'b1, 3'd7, 8'h2A, 15, 1, 1, r);
    e7 = 8'h2A;
    check_state("R8");
    rd_chk(3'd7, "R8 read");
    // R6: unused address
    wr(3'd5, 8'hFF);
    check_state("R6 write");
    rd_chk(3'd5, "R6 read zeros");
    // R9: no counter reset between frames
    xfer(1'b1, 3'd3, 8'h11, 12, 1, 0, r);
    e3 = 8'h11;
    xfer(1'b1, 3'd3, 8'h66, 12, 0, 1, r);
    check_state("R9 ignored");
    rd_chk(3'd3, "R9 read");
    // Random mix
    for (int k = 0; k < 30; k++) begin
      logic [2:0] a;
      a = (k % 3 == 0) ? 3'($urandom) : ((k % 3 == 1) ? 3'd3 : 3'd7);
      wr(a, 8'($urandom));
      boost_req = 1'($urandom);
      ticks(3);
      check_state("R2 R7 random");
      rd_chk(a, "R4 R6 random read");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule